// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits between the write strobe capture of a parallel NOR-style flash and its program/erase engine. Each clock cycle in which `wr_en` is high carries one bus write: an address and a data byte. The decoder follows these writes through fixed unlock prefixes and branches into one of several commands: byte program, chip erase, boot-sector lockout, identification-mode entry and identification-mode exit. For each recognised command it raises a single-cycle pulse. The program pulse carries the target address and data byte.

The decoder also holds two pieces of state. The first is the identification-mode flag. While that flag is set, a read port returns fixed identity bytes and the lockout status. The second is the boot lockout flag, which stands in for a non-volatile bit and is kept in a register. Once lockout is set, program commands aimed at the protected low address range are dropped. Chip erase is then flagged to spare that range. While the engine reports busy, incoming writes are discarded and any partial sequence is held as it was.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, all five command pulses are 0, `id_mode` is 0, `boot_locked` is 0 and `id_data` is 00h.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h, followed by a write of D to address X, give `prog_pulse` high for exactly the one cycle after the fourth write, with `prog_addr`=X and `prog_data`=D.
- R3: The six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h give a one-cycle `erase_pulse` after the sixth write. In that same cycle, `erase_keep_boot` equals `boot_locked`.
- R4: The same six-write sequence ending in 40h@5555h instead of 10h@5555h gives a one-cycle `lock_pulse` and sets `boot_locked`. `boot_locked` then stays 1 until reset.
- R5: While `boot_locked` is 1, a program command whose target address lies in 00000h..01FFFh gives no `prog_pulse`. Targets above 01FFFh are still programmed.
- R6: The writes AAh@5555h, 55h@2AAAh, 90h@5555h pulse `id_entry_pulse` and set `id_mode`. Two forms of exit exist: AAh@5555h, 55h@2AAAh, F0h@5555h, or a single F0h written to any address. Either form pulses `id_exit_pulse` and clears `id_mode`.
- R7: While `id_mode` is 1, `id_data` depends on `rd_addr`. It is 1Fh at address 0 and 17h at address 1. At address 2 it is {7'b0, boot_locked}, so bit 0 set means locked. At any other address it is 00h. While `id_mode` is 0, `id_data` is 00h.
- R8: A write that does not match the next expected step returns the decoder to idle. If that mismatching write is AAh@5555h, the sequence restarts at its second step.
- R9: Only address bits [14:0] are compared with 5555h and 2AAAh, so key writes to 15555h or 12AAAh count as matches.
- R10: A write made while `busy` is 1 changes neither the sequence state nor any output.
- R11: An F0h data byte written as the fourth cycle of a program command is program data, not an exit command.
- R12: At most one of the five command pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | A bus write is present this cycle |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data byte |
| busy | input | 1 | Program/erase engine busy; writes are discarded |
| rd_addr | input | 17 | Read address for identification data |
| id_data | output | 8 | Identification read data |
| prog_pulse | output | 1 | Byte program command |
| prog_addr | output | 17 | Program target address, valid with `prog_pulse` |
| prog_data | output | 8 | Program data, valid with `prog_pulse` |
| erase_pulse | output | 1 | Chip erase command |
| erase_keep_boot | output | 1 | With `erase_pulse`: protected range must be preserved |
| lock_pulse | output | 1 | Boot lockout command |
| id_entry_pulse | output | 1 | Identification-mode entry |
| id_exit_pulse | output | 1 | Identification-mode exit |
| id_mode | output | 1 | Identification mode active |
| boot_locked | output | 1 | Boot range locked |

## Verification
A lockout command can be accepted while identification mode is active and the read port is pointed at the status offset. In that case the status bit on `id_data` must change in the same cycle that `lock_pulse` appears. The bench enters identification mode and parks `rd_addr` at offset 2. It confirms that the status bit reads 0, then issues the six-write lockout. At the sample that shows `lock_pulse`, it requires `id_data` to be 01h.

A second overlap occurs when `busy` coincides with a write in the middle of a sequence. The bench judges this case by whether the interrupted sequence later completes unchanged.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W = 17,
  parameter int CMP_W  = 15,
  parameter logic [ADDR_W-1:0] BOOT_LAST = 'h1FFF,
  parameter logic [7:0] MFR_CODE = 8'h1F,
  parameter logic [7:0] DEV_CODE = 8'h17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        id_data,
  output logic              prog_pulse,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              erase_pulse,
  output logic              erase_keep_boot,
  output logic              lock_pulse,
  output logic              id_entry_pulse,
  output logic              id_exit_pulse,
  output logic              id_mode,
  output logic              boot_locked
);

  localparam logic [CMP_W-1:0] KEY_A = CMP_W'(16'h5555);
  localparam logic [CMP_W-1:0] KEY_B = CMP_W'(16'h2AAA);

  typedef enum logic [2:0] {
    IDLE, GOT_AA, GOT_55, WANT_DATA, GOT_80, GOT_AA2, GOT_55B
  } step_t;

  step_t state, state_nx;
  logic  p_prog, p_erase, p_lock, p_entry, p_exit;

  wire take    = wr_en && !busy;
  wire at_a    = wr_addr[CMP_W-1:0] == KEY_A;
  wire at_b    = wr_addr[CMP_W-1:0] == KEY_B;
  wire aa_a    = at_a && wr_data == 8'hAA;
  wire k55_b   = at_b && wr_data == 8'h55;
  wire is_f0   = wr_data == 8'hF0;
  wire in_boot = wr_addr <= BOOT_LAST;
  wire mis_nx  = aa_a;

  always_comb begin
    state_nx = state;
    p_prog   = 1'b0;
    p_erase  = 1'b0;
    p_lock   = 1'b0;
    p_entry  = 1'b0;
    p_exit   = 1'b0;
    if (take) begin
      if (state == WANT_DATA) begin
        p_prog   = !(boot_locked && in_boot);
        state_nx = IDLE;
      end else if (is_f0) begin
        p_exit   = 1'b1;
        state_nx = IDLE;
      end else begin
        state_nx = mis_nx ? GOT_AA : IDLE;
        case (state)
          IDLE:    if (aa_a) state_nx = GOT_AA;
          GOT_AA:  if (k55_b) state_nx = GOT_55;
          GOT_55:
            if (at_a) begin
              case (wr_data)
                8'hA0: state_nx = WANT_DATA;
                8'h80: state_nx = GOT_80;
                8'h90: begin p_entry = 1'b1; state_nx = IDLE; end
                default: ;
              endcase
            end
          GOT_80:  if (aa_a) state_nx = GOT_AA2;
          GOT_AA2: if (k55_b) state_nx = GOT_55B;
          GOT_55B:
            if (at_a) begin
              if (wr_data == 8'h10) begin p_erase = 1'b1; state_nx = IDLE; end
              else if (wr_data == 8'h40) begin p_lock = 1'b1; state_nx = IDLE; end
            end
          default: state_nx = IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state           <= IDLE;
      prog_pulse      <= 1'b0;
      prog_addr       <= '0;
      prog_data       <= '0;
      erase_pulse     <= 1'b0;
      erase_keep_boot <= 1'b0;
      lock_pulse      <= 1'b0;
      id_entry_pulse  <= 1'b0;
      id_exit_pulse   <= 1'b0;
      id_mode         <= 1'b0;
      boot_locked     <= 1'b0;
    end else begin
      state           <= state_nx;
      prog_pulse      <= p_prog;
      erase_pulse     <= p_erase;
      erase_keep_boot <= p_erase && boot_locked;
      lock_pulse      <= p_lock;
      id_entry_pulse  <= p_entry;
      id_exit_pulse   <= p_exit;
      if (p_prog) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (p_entry) id_mode <= 1'b1;
      else if (p_exit) id_mode <= 1'b0;
      if (p_lock) boot_locked <= 1'b1;
    end
  end

  always_comb begin
    id_data = 8'h00;
    if (id_mode) begin
      if (rd_addr == ADDR_W'(0)) id_data = MFR_CODE;
      else if (rd_addr == ADDR_W'(1)) id_data = DEV_CODE;
      else if (rd_addr == ADDR_W'(2)) id_data = {7'b0, boot_locked};
    end
  end

endmodule

module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 17,
  parameter logic [ADDR_W-1:0] BOOT_LAST = 'h1FFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              busy,
  input logic              prog_pulse,
  input logic [ADDR_W-1:0] prog_addr,
  input logic              erase_pulse,
  input logic              erase_keep_boot,
  input logic              lock_pulse,
  input logic              id_entry_pulse,
  input logic              id_exit_pulse,
  input logic              id_mode,
  input logic              boot_locked
);

  a_r12_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_pulse, erase_pulse, lock_pulse, id_entry_pulse, id_exit_pulse}));

  a_r5_no_boot_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_pulse && boot_locked) |-> (prog_addr > BOOT_LAST));

  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    boot_locked |=> boot_locked);

  a_r4_lock_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_locked) |-> lock_pulse);

  a_r6_id_enter: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> id_entry_pulse);

  a_r6_id_leave: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_mode) |-> id_exit_pulse);

  a_r10_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> !(prog_pulse || erase_pulse || lock_pulse || id_entry_pulse || id_exit_pulse));

  a_r3_keep_boot: assert property (@(posedge clk) disable iff (!rst_n)
    erase_pulse |-> (erase_keep_boot == boot_locked));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .BOOT_LAST(BOOT_LAST)) chk_i (.*);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 29;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic [16:0] rd_addr = '0;
  logic [7:0]  id_data;
  logic        prog_pulse, erase_pulse, erase_keep_boot, lock_pulse;
  logic        id_entry_pulse, id_exit_pulse, id_mode, boot_locked;
  logic [16:0] prog_addr;
  logic [7:0]  prog_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .rd_addr(rd_addr), .id_data(id_data),
    .prog_pulse(prog_pulse), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_pulse(erase_pulse), .erase_keep_boot(erase_keep_boot),
    .lock_pulse(lock_pulse), .id_entry_pulse(id_entry_pulse),
    .id_exit_pulse(id_exit_pulse), .id_mode(id_mode), .boot_locked(boot_locked)
  );

  // {busy, addr, data, expected {prog, erase, lock, entry, exit}}
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 17'h05555, 8'hAA, 5'b00000},
    {1'b0, 17'h02AAA, 8'h55, 5'b00000},
    {1'b0, 17'h05555, 8'hA0, 5'b00000},
    {1'b0, 17'h00100, 8'h34, 5'b10000},  // R2 program, unlocked boot range
    {1'b0, 17'h15555, 8'hAA, 5'b00000},  // R9 high bits ignored
    {1'b0, 17'h12AAA, 8'h55, 5'b00000},
    {1'b0, 17'h05555, 8'h80, 5'b00000},
    {1'b0, 17'h05555, 8'hAA, 5'b00000},
    {1'b0, 17'h02AAA, 8'h55, 5'b00000},
    {1'b0, 17'h05555, 8'h10, 5'b01000},  // R3 erase
    {1'b0, 17'h05555, 8'hAA, 5'b00000},
    {1'b0, 17'h02AAA, 8'h55, 5'b00000},
    {1'b0, 17'h05555, 8'h90, 5'b00010},  // R6 entry
    {1'b0, 17'h01234, 8'hF0, 5'b00001},  // R6 single-write exit
    {1'b0, 17'h05555, 8'hAA, 5'b00000},
    {1'b0, 17'h02AAA, 8'h33, 5'b00000},  // R8 mismatch
    {1'b0, 17'h02AAA, 8'h55, 5'b00000},
    {1'b0, 17'h05555, 8'hA0, 5'b00000},
    {1'b0, 17'h05555, 8'hAA, 5'b00000},
    {1'b0, 17'h05555, 8'hAA, 5'b00000},  // R8 restart
    {1'b0, 17'h02AAA, 8'h55, 5'b00000},
    {1'b0, 17'h05555, 8'hA0, 5'b00000},
    {1'b0, 17'h04000, 8'hF0, 5'b10000},  // R11 F0 as data
    {1'b0, 17'h05555, 8'hAA, 5'b00000},
    {1'b1, 17'h00000, 8'h77, 5'b00000},  // R10 busy
    {1'b1, 17'h05555, 8'hAA, 5'b00000},
    {1'b0, 17'h02AAA, 8'h55, 5'b00000},
    {1'b0, 17'h05555, 8'hA0, 5'b00000},
    {1'b0, 17'h02000, 8'h12, 5'b10000}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic b, input logic [16:0] a, input logic [7:0] d);
    wr_en = 1'b1; busy = b; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; busy = 1'b0;
  endtask

  function automatic logic [4:0] pulses();
    return {prog_pulse, erase_pulse, lock_pulse, id_entry_pulse, id_exit_pulse};
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({pulses(), id_mode, boot_locked, id_data} == 15'd0, "R1 reset state",
        {pulses(), id_mode, boot_locked, id_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][30], VEC[i][29:13], VEC[i][12:5]);
      // R12 also covered: expected vectors are one-hot or zero
      chk(pulses() == VEC[i][4:0], $sformatf("R2/R3/R6/R8/R9/R10/R11 vector %0d pulses", i),
          pulses(), VEC[i][4:0]);
      if (VEC[i][4])
        chk({prog_addr, prog_data} == VEC[i][29:5], $sformatf("R2 vector %0d addr/data", i),
            {prog_addr, prog_data}, VEC[i][29:5]);
    end

    rd_addr = 17'd0;
    @(negedge clk);
    chk(id_data == 8'h00, "R7 id_data outside id mode", id_data, 8'h00);

    wr(0, 17'h05555, 8'hAA); wr(0, 17'h02AAA, 8'h55); wr(0, 17'h05555, 8'h90);
    chk(id_mode == 1'b1, "R6 id_mode set", id_mode, 1);
    chk(id_data == 8'h1F, "R7 manufacturer code", id_data, 8'h1F);
    rd_addr = 17'd1; #1;
    chk(id_data == 8'h17, "R7 device code", id_data, 8'h17);
    rd_addr = 17'd3; #1;
    chk(id_data == 8'h00, "R7 other offset", id_data, 8'h00);
    rd_addr = 17'd2; #1;
    chk(id_data == 8'h00, "R7 unlocked status", id_data, 8'h00);

    wr(0, 17'h05555, 8'hAA); wr(0, 17'h02AAA, 8'h55); wr(0, 17'h05555, 8'h80);
    wr(0, 17'h05555, 8'hAA); wr(0, 17'h02AAA, 8'h55); wr(0, 17'h05555, 8'h40);
    chk(pulses() == 5'b00100, "R4 lock pulse", pulses(), 5'b00100);
    chk(id_data == 8'h01, "R7 status same cycle as R4 lock", id_data, 8'h01);
    chk(boot_locked == 1'b1, "R4 boot_locked set", boot_locked, 1);

    wr(0, 17'h05555, 8'hAA); wr(0, 17'h02AAA, 8'h55); wr(0, 17'h05555, 8'hF0);
    chk(pulses() == 5'b00001 && !id_mode, "R6 three-write exit", {pulses(), id_mode}, 6'b000010);

    wr(0, 17'h05555, 8'hAA); wr(0, 17'h02AAA, 8'h55); wr(0, 17'h05555, 8'hA0);
    wr(0, 17'h01FFF, 8'h55);
    chk(prog_pulse == 1'b0, "R5 locked boot program dropped", prog_pulse, 0);

    wr(0, 17'h05555, 8'hAA); wr(0, 17'h02AAA, 8'h55); wr(0, 17'h05555, 8'hA0);
    wr(0, 17'h02000, 8'h66);
    chk(prog_pulse && prog_addr == 17'h02000 && prog_data == 8'h66, "R5 program above range",
        {prog_pulse, prog_addr, prog_data}, {1'b1, 17'h02000, 8'h66});

    wr(0, 17'h05555, 8'hAA); wr(0, 17'h02AAA, 8'h55); wr(0, 17'h05555, 8'h80);
    wr(0, 17'h05555, 8'hAA); wr(0, 17'h02AAA, 8'h55); wr(0, 17'h05555, 8'h10);
    chk(erase_pulse && erase_keep_boot, "R3 erase keeps boot", {erase_pulse, erase_keep_boot}, 2'b11);

    @(negedge clk);
    chk(pulses() == 5'd0 && boot_locked, "R2/R4 pulses single-cycle, lock sticky",
        {pulses(), boot_locked}, 6'b000001);

    rst_n = 1'b0;
    @(negedge clk);
    chk({pulses(), id_mode, boot_locked} == 7'd0, "R1 reset clears lock",
        {pulses(), id_mode, boot_locked}, 0);

    summary();
  end
endmodule